// File: doc/BRIEF.md
# Gated Intermediate-Frequency Counter

This peripheral measures the frequency of one of two external intermediate-frequency signals, an AM path and an FM path. Software writes an 8-bit control word that picks the input, sets a gate length in whole milliseconds, and starts the measurement. While the gate is open, each rising edge of the chosen input adds one to a count register. The gate length is derived from the system clock. The FM path has a divide-by-two prescaler, so its count is half the number of input edges.

When the gate closes, the run bit clears by itself and a done flag rises. The count is held until the next start. A halt input freezes the measurement without losing any state. A clock-stop indication clears the control word but keeps the count.

Top module: `ifc_gated_counter`

## Requirements
- R1: After reset the control readback, the count and the done flag are all zero.
- R2: A write with bit 7 = 1 and gate code N (bits 3:0) from 1 to 15 does four things: it clears the count, the FM prescaler and the done flag, and it opens the gate for exactly N × TICK_CYCLES clock cycles. The done flag rises N × TICK_CYCLES cycles after the write edge. At that point readback bit 7 returns to 0 and the other control bits keep their written values.
- R3: With select bits 6:5 = 01, the count is the number of rising edges on `am_in` seen while the gate is open. The count never steps by more than one per cycle.
- R4: With select bits 6:5 = 10, the count is floor(E/2), where E is the number of rising edges on `fm_in` seen while the gate is open. The prescaler starts from zero at every start.
- R5: Select values 00 and 11 count nothing. The input that is not selected has no effect on the count.
- R6: The count keeps its value after the gate expires. It also keeps its value after a write with bit 7 = 0, and edges arriving after either event do not change it. A stop write leaves the done flag unchanged.
- R7: A start with gate code 0 gives done = 1, count = 0 and readback bit 7 = 0 right after the write edge.
- R8: While `halt` is high, the count, the gate timer and the control register hold their values. Register writes and input edges are ignored during that time.
- R9: A cycle with `clk_stop` high clears the control register to zero and keeps the count.
- R10: The count saturates at 2^COUNT_W − 1 and does not wrap.
- R11: Bit 4 is stored and read back, but it has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the gate timebase |
| rst_n | input | 1 | Active-low power-on reset |
| clk_stop | input | 1 | Clock-stop indication; clears the control register |
| halt | input | 1 | Freezes the measurement and blocks writes |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control word: [7] run, [6:5] select, [4] test, [3:0] gate ms |
| am_in | input | 1 | AM intermediate-frequency input (asynchronous) |
| fm_in | input | 1 | FM intermediate-frequency input (asynchronous) |
| ctrl_rd | output | 8 | Control register readback |
| count_rd | output | COUNT_W | Held or running edge count |
| done | output | 1 | Gate expired since the last start |

## Verification
The hardest case to reach is a halt that falls in the middle of an open gate. The frozen timer has to resume where it stopped, and edges that arrive during the halt must be dropped. The stimulus starts a short gate and sends a few pulses. It then raises halt for far longer than the whole gate, with pulses and a stop write applied during the halt. After releasing halt it sends more pulses. The final count then shows that only the edges outside the halt were counted. Saturation is reached by building the bench with a narrow count width.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    typedef struct packed {
        logic       run;
        logic [1:0] sel;
        logic       tst;
        logic [3:0] gate;
    } ifc_ctrl_t;

    localparam logic [1:0] SEL_NONE = 2'b00;
    localparam logic [1:0] SEL_AM   = 2'b01;
    localparam logic [1:0] SEL_FM   = 2'b10;

endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
    parameter int N_IN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] in_async,
    output logic [N_IN-1:0] rise
);
    for (genvar g = 0; g < N_IN; g++) begin : g_ch
        logic [2:0] sh_d, sh_q;   // [0] meta, [1] stable, [2] history

        always_comb begin
            sh_d = {sh_q[1:0], in_async[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign rise[g] = sh_q[1] & ~sh_q[2];
    end
endmodule

// File: rtl/ifc_prescale.sv
module ifc_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic edge_in,
    output logic pass
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (clear)        phase_d = 1'b0;
        else if (edge_in) phase_d = ~phase_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    // every second qualified edge passes
    assign pass = edge_in & phase_q & ~clear;
endmodule

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer #(
    parameter int TICK_CYCLES = 4500,
    parameter int GATE_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic              hold,
    input  logic [GATE_W-1:0] code,
    output logic              expire
);
    localparam int TICK_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [GATE_W-1:0] ms;
    } tmr_t;

    tmr_t tm_d, tm_q;
    logic tick_end;

    assign tick_end = (tm_q.tick == TICK_LAST);
    assign expire   = run && !hold && !restart && tick_end
                      && (tm_q.ms == code - 1'b1);

    always_comb begin
        tm_d = tm_q;
        if (restart) begin
            tm_d = '0;
        end else if (hold) begin
            tm_d = tm_q;
        end else if (!run) begin
            tm_d = '0;
        end else if (tick_end) begin
            tm_d.tick = '0;
            tm_d.ms   = tm_q.ms + 1'b1;
        end else begin
            tm_d.tick = tm_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end
endmodule

// File: rtl/ifc_gated_counter.sv
module ifc_gated_counter
    import ifc_pkg::*;
#(
    parameter int TICK_CYCLES = 4500,
    parameter int COUNT_W     = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_stop,
    input  logic               halt,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               am_in,
    input  logic               fm_in,
    output logic [7:0]         ctrl_rd,
    output logic [COUNT_W-1:0] count_rd,
    output logic               done
);
    localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

    typedef struct packed {
        ifc_ctrl_t          ctrl;
        logic               done;
        logic [COUNT_W-1:0] count;
    } st_t;

    st_t  st_d, st_q;
    logic [1:0] rise;
    logic wr_go, start, live, fm_edge, fm_pass, expire, hit;

    assign wr_go = wr_en && !halt && !clk_stop;
    assign start = wr_go && wr_data[7];
    assign live  = st_q.ctrl.run && !halt && !clk_stop && !wr_go;

    ifc_edge_sync #(.N_IN(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_async ({fm_in, am_in}),
        .rise     (rise)
    );

    assign fm_edge = live && (st_q.ctrl.sel == SEL_FM) && rise[1];

    ifc_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .edge_in (fm_edge),
        .pass    (fm_pass)
    );

    ifc_gate_timer #(.TICK_CYCLES(TICK_CYCLES), .GATE_W(4)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (st_q.ctrl.run && !clk_stop && !wr_go),
        .hold    (halt),
        .code    (st_q.ctrl.gate),
        .expire  (expire)
    );

    always_comb begin
        case (st_q.ctrl.sel)
            SEL_AM:  hit = rise[0];
            SEL_FM:  hit = fm_pass;
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (clk_stop) begin
            st_d.ctrl = '0;
        end else if (wr_go) begin
            st_d.ctrl = ifc_ctrl_t'(wr_data);
            if (wr_data[7]) begin
                st_d.count = '0;
                st_d.done  = 1'b0;
                if (wr_data[3:0] == 4'd0) begin
                    st_d.ctrl.run = 1'b0;
                    st_d.done     = 1'b1;
                end
            end
        end else if (live) begin
            if (hit && st_q.count != CNT_MAX) st_d.count = st_q.count + 1'b1;
            if (expire) begin
                st_d.ctrl.run = 1'b0;
                st_d.done     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_rd  = st_q.ctrl;
    assign count_rd = st_q.count;
    assign done     = st_q.done;
endmodule

// File: rtl/ifc_gated_counter_chk.sv
module ifc_gated_counter_chk #(
    parameter int COUNT_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clk_stop,
    input logic               halt,
    input logic               wr_en,
    input logic [7:0]         wr_data,
    input logic [7:0]         ctrl_rd,
    input logic [COUNT_W-1:0] count_rd,
    input logic               done
);
    localparam logic [COUNT_W-1:0] TOP = {COUNT_W{1'b1}};
    logic go;
    assign go = wr_en && wr_data[7] && !halt && !clk_stop;

    p_done_ends_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !ctrl_rd[7]);

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (count_rd == $past(count_rd)) || (count_rd == $past(count_rd) + 1'b1));

    p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rd[7] && !go) |=> $stable(count_rd));

    p_code_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && wr_data[3:0] == 4'd0) |=> (done && count_rd == '0 && !ctrl_rd[7]));

    p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clk_stop) |=> ($stable(count_rd) && $stable(ctrl_rd) && $stable(done)));

    p_clkstop_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop |=> (ctrl_rd == 8'h00 && $stable(count_rd)));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (count_rd == TOP && !go) |=> count_rd == TOP);
endmodule

bind ifc_gated_counter ifc_gated_counter_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_stop (clk_stop),
    .halt     (halt),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ctrl_rd  (ctrl_rd),
    .count_rd (count_rd),
    .done     (done)
);

// File: tb/ifc_gated_counter_bench.sv
module ifc_gated_counter_bench;
    localparam int TICK = 20;
    localparam int CW   = 6;

    logic          clk = 0, rst_n = 0, clk_stop = 0, halt = 0, wr_en = 0;
    logic [7:0]    wr_data = '0;
    logic          am_in = 0, fm_in = 0;
    logic [7:0]    ctrl_rd;
    logic [CW-1:0] count_rd;
    logic          done;

    int n_chk = 0, n_bad = 0, cyc = 0, w_cyc = 0, done_cyc = 0;
    bit finished = 0;
    int    exp_q[$];
    string tag_q[$];

    ifc_gated_counter #(.TICK_CYCLES(TICK), .COUNT_W(CW)) u_ifc_gated_counter (
        .clk(clk), .rst_n(rst_n), .clk_stop(clk_stop), .halt(halt),
        .wr_en(wr_en), .wr_data(wr_data), .am_in(am_in), .fm_in(fm_in),
        .ctrl_rd(ctrl_rd), .count_rd(count_rd), .done(done));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: compares the held count on each rising done flag
    logic prev_done = 0;
    always @(negedge clk) begin
        if (rst_n && done && !prev_done) begin
            done_cyc = cyc;
            if (exp_q.size() == 0) check("R2 unexpected done", 1, 0);
            else check(tag_q.pop_front(), int'(count_rd), exp_q.pop_front());
        end
        prev_done = done;
    end

    task automatic write_reg(logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(posedge clk); #1 wr_en = 0; w_cyc = cyc;
    endtask

    task automatic pulses(bit on_am, bit on_fm, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); am_in = on_am; fm_in = on_fm;
            @(negedge clk);
            @(negedge clk); am_in = 0; fm_in = 0;
            @(negedge clk);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
        @(negedge clk);
    endtask

    // driver: start, stimulate, expect
    task automatic measure(logic [7:0] c, bit a, bit f, int n, int exp, string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        write_reg(c);
        idle(4);
        pulses(a, f, n);
        wait_done();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        check("R1 ctrl", ctrl_rd, 0);
        check("R1 count", count_rd, 0);
        check("R1 done", done, 0);
        rst_n = 1;
        idle(2);

        // AM, gate 3 ms, test bit set
        measure(8'hB3, 1, 0, 10, 10, "R3 AM count");
        check("R2 gate length", done_cyc - w_cyc, 3 * TICK);
        check("R2 R11 ctrl after expiry", ctrl_rd, 8'h33);

        // FM halving and prescaler restart
        measure(8'hC5, 0, 1, 15, 7, "R4 FM count");
        measure(8'hC5, 0, 1, 3, 1, "R4 R2 prescaler cleared");

        // no input / unused select / unselected input
        measure(8'h83, 1, 1, 5, 0, "R5 sel none");
        measure(8'hE3, 1, 1, 5, 0, "R5 sel unused");
        measure(8'hA3, 0, 1, 5, 0, "R5 unselected FM");

        // saturation then hold after expiry
        measure(8'hAF, 1, 0, 70, 63, "R10 saturate");
        pulses(1, 0, 5); idle(4);
        check("R6 held after expiry", count_rd, 63);

        // gate code 0
        write_reg(8'hA0);
        @(negedge clk);
        check("R7 done", done, 1);
        check("R7 count", count_rd, 0);
        check("R7 run bit", ctrl_rd[7], 0);

        // software stop
        write_reg(8'hAF); idle(4);
        pulses(1, 0, 5); idle(4);
        write_reg(8'h2F); idle(1);
        check("R6 stop ctrl", ctrl_rd, 8'h2F);
        check("R6 stop count", count_rd, 5);
        pulses(1, 0, 5); idle(320);
        check("R6 count after stop", count_rd, 5);
        check("R6 done unchanged", done, 0);

        // halt mid-gate
        exp_q.push_back(5); tag_q.push_back("R8 count after halt");
        write_reg(8'hA2); idle(4);
        pulses(1, 0, 3); idle(6);
        halt = 1;
        pulses(1, 0, 5);
        write_reg(8'h00);
        idle(200);
        check("R8 count frozen", count_rd, 3);
        check("R8 done frozen", done, 0);
        check("R8 ctrl frozen", ctrl_rd, 8'hA2);
        halt = 0; idle(2);
        pulses(1, 0, 2);
        wait_done();

        // clock stop
        write_reg(8'hAF); idle(4);
        pulses(1, 0, 4); idle(4);
        clk_stop = 1; idle(1); clk_stop = 0; idle(1);
        check("R9 ctrl cleared", ctrl_rd, 0);
        check("R9 count kept", count_rd, 4);
        idle(400);
        check("R9 no done", done, 0);

        check("R2 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule